// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Exception Entry

This block is the control state machine for a 32-bit load/store processor that takes several clock cycles per instruction. Every cycle it drives the select, function and write-enable lines of a separate datapath. It steps through these phases:

- instruction fetch
- decode
- the class-specific phases:
  - memory reference
  - register-register operation
  - conditional branch
  - jump

Two extra states send control to a fixed exception handler. One handles an opcode that the decoder does not recognise. The other handles a register-register operation whose ALU result overflowed.

Each exception state does four things in the same cycle:

- It has the ALU form PC minus 4, which is the address of the faulting instruction, for the saved-PC register.
- It writes a cause code.
- It loads the program counter from the handler-address input of the PC multiplexer.
- It keeps every register-file and memory write enable low.

The overflow flag is taken at the clock edge that ends the execute phase. The flag therefore picks between normal completion and the exception state, and the faulting result is never written back.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: Synchronous active-high reset puts the sequencer in fetch. Fetch drives mem_rd=1, instr_we=1, pc_we=1, addr_from_alu=0, a_sel=0, b_sel=01, alu_func=00 and pc_src=00, and it always moves on to decode.
- R2: Decode drives a_sel=0, b_sel=11 and alu_func=00. It picks the next state from the 6-bit opcode:
  - 0x00 (register-register) goes to execute.
  - 0x23 (load) and 0x2B (store) go to address compute.
  - 0x04 (branch-if-equal) goes to branch.
  - 0x02 (jump) goes to jump.
- R3: Every other opcode leads from decode to the undefined-opcode state. That state drives:
  - cause_code=0 and cause_we=1
  - a_sel=0, b_sel=01 and alu_func=01
  - epc_we=1 and pc_we=1
  - pc_src=11
  
  It returns to fetch next.
- R4: Execute drives a_sel=1, b_sel=00 and alu_func=10. If alu_overflow is high at the clock edge that ends execute, the next state is the overflow state; otherwise the next state is completion.
- R5: Completion drives dst_rd_sel=1, wb_from_mem=0 and rf_we=1, then returns to fetch. On the overflow path rf_we stays low in every cycle up to the next fetch.
- R6: The overflow state drives the same outputs as the undefined-opcode state, except cause_code=1. It then returns to fetch.
- R7: The memory-reference phases run as follows:
  - Address compute (a_sel=1, b_sel=10, alu_func=00) leads to the read for a load and to the write for a store.
  - The read drives mem_rd=1 and addr_from_alu=1, then goes to write-back.
  - Write-back drives rf_we=1, wb_from_mem=1 and dst_rd_sel=0, then goes to fetch.
  - The write drives mem_wr=1 and addr_from_alu=1, then goes to fetch.
- R8: Branch drives a_sel=1, b_sel=00, alu_func=01, pc_we_if_zero=1 and pc_src=01. Jump drives pc_we=1 and pc_src=10. Both return to fetch.
- R9: Every control output not named for a state is 0 in that state. alu_overflow has no effect in any state other than execute.
- R10: alu_func uses these codes: 00 means add, 01 means subtract, and 10 means the operation is taken from the instruction's function field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the held instruction |
| alu_overflow | input | 1 | Signed overflow flag from the ALU |
| a_sel | output | 1 | ALU A operand: 0 = PC, 1 = register A |
| b_sel | output | 2 | ALU B operand: 00 = reg B, 01 = constant 4, 10 = sign-extended immediate, 11 = shifted immediate |
| alu_func | output | 2 | ALU function code (see R10) |
| dst_rd_sel | output | 1 | Destination register from the rd field |
| rf_we | output | 1 | Register-file write enable |
| wb_from_mem | output | 1 | Write-back data from memory data register |
| addr_from_alu | output | 1 | Memory address from ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| instr_we | output | 1 | Instruction register load |
| pc_we | output | 1 | Unconditional PC load |
| pc_we_if_zero | output | 1 | PC load when the ALU result is zero |
| pc_src | output | 2 | PC source: 00 = ALU, 01 = ALU result register, 10 = jump target, 11 = handler address |
| epc_we | output | 1 | Saved-PC register load |
| cause_we | output | 1 | Cause register load |
| cause_code | output | 1 | Cause value: 0 = undefined opcode, 1 = overflow |

## Verification
The overflow exit is the hardest path to reach from the ports. The flag counts only in the single cycle that ends execute, and that cycle comes two states after the opcode is applied. The bench runs a cycle-accurate model of the sequence next to the design. It sweeps all 64 opcodes, once with alu_overflow held low for the whole instruction and once with it held high, so the flag is present in execute and in every state where it must be ignored. A reset applied partway through a load covers the return to fetch from an inner state.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OP_W = 6;
    localparam int ST_W = 4;

    localparam logic [OP_W-1:0] OPC_RREG  = 6'h00;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_MADDR  = 4'd2,
        ST_MREAD  = 4'd3,
        ST_MWB    = 4'd4,
        ST_MWRITE = 4'd5,
        ST_EXEC   = 4'd6,
        ST_RDONE  = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9,
        ST_UNDEF  = 4'd10,
        ST_OVF    = 4'd11
    } state_e;

    typedef enum logic [1:0] {
        FN_ADD   = 2'b00,
        FN_SUB   = 2'b01,
        FN_FIELD = 2'b10
    } alu_fn_e;

    typedef struct packed {
        logic       a_sel;
        logic [1:0] b_sel;
        alu_fn_e    alu_func;
        logic       dst_rd_sel;
        logic       rf_we;
        logic       wb_from_mem;
        logic       addr_from_alu;
        logic       mem_rd;
        logic       mem_wr;
        logic       instr_we;
        logic       pc_we;
        logic       pc_we_if_zero;
        logic [1:0] pc_src;
        logic       epc_we;
        logic       cause_we;
        logic       cause_code;
    } ctrl_t;

    // Decode dispatch: unknown opcodes fall to the undefined-opcode state.
    function automatic state_e dispatch(input logic [OP_W-1:0] op);
        case (op)
            OPC_RREG:            return ST_EXEC;
            OPC_LOAD, OPC_STORE: return ST_MADDR;
            OPC_BEQ:             return ST_BRANCH;
            OPC_JUMP:            return ST_JUMP;
            default:             return ST_UNDEF;
        endcase
    endfunction

endpackage

// File: rtl/mc_next_state.sv
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  state_e              cur,
    input  logic [OP_W-1:0]     opcode,
    input  logic                alu_overflow,
    output state_e              nxt
);
    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = dispatch(opcode);
            ST_MADDR:  nxt = (opcode == OPC_STORE) ? ST_MWRITE : ST_MREAD;
            ST_MREAD:  nxt = ST_MWB;
            ST_EXEC:   nxt = alu_overflow ? ST_OVF : ST_RDONE;
            default:   nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  state_e cur,
    output ctrl_t  ctl
);
    always_comb begin
        ctl = '0;
        case (cur)
            ST_FETCH: begin
                ctl.mem_rd   = 1'b1;
                ctl.instr_we = 1'b1;
                ctl.pc_we    = 1'b1;
                ctl.b_sel    = 2'b01;
                ctl.alu_func = FN_ADD;
            end
            ST_DECODE: begin
                ctl.b_sel    = 2'b11;
                ctl.alu_func = FN_ADD;
            end
            ST_MADDR: begin
                ctl.a_sel    = 1'b1;
                ctl.b_sel    = 2'b10;
                ctl.alu_func = FN_ADD;
            end
            ST_MREAD: begin
                ctl.mem_rd        = 1'b1;
                ctl.addr_from_alu = 1'b1;
            end
            ST_MWB: begin
                ctl.rf_we       = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            ST_MWRITE: begin
                ctl.mem_wr        = 1'b1;
                ctl.addr_from_alu = 1'b1;
            end
            ST_EXEC: begin
                ctl.a_sel    = 1'b1;
                ctl.b_sel    = 2'b00;
                ctl.alu_func = FN_FIELD;
            end
            ST_RDONE: begin
                ctl.dst_rd_sel = 1'b1;
                ctl.rf_we      = 1'b1;
            end
            ST_BRANCH: begin
                ctl.a_sel         = 1'b1;
                ctl.alu_func      = FN_SUB;
                ctl.pc_we_if_zero = 1'b1;
                ctl.pc_src        = 2'b01;
            end
            ST_JUMP: begin
                ctl.pc_we  = 1'b1;
                ctl.pc_src = 2'b10;
            end
            ST_UNDEF, ST_OVF: begin
                ctl.b_sel      = 2'b01;
                ctl.alu_func   = FN_SUB;
                ctl.epc_we     = 1'b1;
                ctl.pc_we      = 1'b1;
                ctl.pc_src     = 2'b11;
                ctl.cause_we   = 1'b1;
                ctl.cause_code = (cur == ST_OVF);
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_overflow,
    output logic            a_sel,
    output logic [1:0]      b_sel,
    output logic [1:0]      alu_func,
    output logic            dst_rd_sel,
    output logic            rf_we,
    output logic            wb_from_mem,
    output logic            addr_from_alu,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            instr_we,
    output logic            pc_we,
    output logic            pc_we_if_zero,
    output logic [1:0]      pc_src,
    output logic            epc_we,
    output logic            cause_we,
    output logic            cause_code
);
    state_e state_q;
    state_e state_d;
    ctrl_t  ctl;

    mc_next_state u_next (
        .cur          (state_q),
        .opcode       (opcode),
        .alu_overflow (alu_overflow),
        .nxt          (state_d)
    );

    mc_ctrl_decode u_dec (
        .cur (state_q),
        .ctl (ctl)
    );

    // The state register also holds the overflow sample taken at the end of execute.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    assign a_sel         = ctl.a_sel;
    assign b_sel         = ctl.b_sel;
    assign alu_func      = ctl.alu_func;
    assign dst_rd_sel    = ctl.dst_rd_sel;
    assign rf_we         = ctl.rf_we;
    assign wb_from_mem   = ctl.wb_from_mem;
    assign addr_from_alu = ctl.addr_from_alu;
    assign mem_rd        = ctl.mem_rd;
    assign mem_wr        = ctl.mem_wr;
    assign instr_we      = ctl.instr_we;
    assign pc_we         = ctl.pc_we;
    assign pc_we_if_zero = ctl.pc_we_if_zero;
    assign pc_src        = ctl.pc_src;
    assign epc_we        = ctl.epc_we;
    assign cause_we      = ctl.cause_we;
    assign cause_code    = ctl.cause_code;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
    input logic       clk,
    input logic       rst,
    input logic       alu_overflow,
    input logic [1:0] b_sel,
    input logic [1:0] alu_func,
    input logic       dst_rd_sel,
    input logic       rf_we,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       instr_we,
    input logic       pc_we,
    input logic       addr_from_alu,
    input logic       epc_we,
    input logic       cause_we,
    input logic       cause_code
);
    AST_RESET_FETCH: assert property (@(posedge clk)
        rst |=> (mem_rd && instr_we && pc_we && !addr_from_alu)); // R1

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        instr_we |=> (b_sel == 2'b11 && !instr_we)); // R2

    AST_EXC_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        cause_we |=> (mem_rd && instr_we && !cause_we)); // R3

    AST_OVERFLOW_DIVERT: assert property (@(posedge clk) disable iff (rst)
        (alu_func == 2'b10 && alu_overflow) |=> (cause_we && cause_code && epc_we && !rf_we)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (alu_func == 2'b10 && !alu_overflow) |=> (rf_we && dst_rd_sel && !cause_we)); // R5

    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr})); // R7

    AST_EXC_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        cause_we |-> (!rf_we && !mem_wr)); // R6
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (.*);

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic       alu_overflow = 1'b0;
    logic       a_sel, dst_rd_sel, rf_we, wb_from_mem, addr_from_alu;
    logic       mem_rd, mem_wr, instr_we, pc_we, pc_we_if_zero;
    logic       epc_we, cause_we, cause_code;
    logic [1:0] b_sel, alu_func, pc_src;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    mc_ctrl_fsm dut (.*);

    // Control vector: a,b[2],fn[2],dst,rfwe,wbm,addr,mrd,mwr,iwe,pcwe,pcwz,src[2],epc,cwe,code
    function automatic logic [19:0] exp_ctrl(input int s);
        logic [19:0] v = '0;
        case (s)
            0:  v = {1'b0,2'b01,2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,3'b000};
            1:  v = {1'b0,2'b11,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,3'b000};
            2:  v = {1'b1,2'b10,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,3'b000};
            3:  v = {1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,3'b000};
            4:  v = {1'b0,2'b00,2'b00,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,3'b000};
            5:  v = {1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,3'b000};
            6:  v = {1'b1,2'b00,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,3'b000};
            7:  v = {1'b0,2'b00,2'b00,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,3'b000};
            8:  v = {1'b1,2'b00,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,3'b000};
            9:  v = {1'b0,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b10,3'b000};
            10: v = {1'b0,2'b01,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b11,3'b110};
            11: v = {1'b0,2'b01,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b11,3'b111};
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic int model_next(input int s, input logic [5:0] op, input logic ov);
        case (s)
            0: return 1;
            1: begin
                if (op == 6'h00) return 6;
                if (op == 6'h23 || op == 6'h2B) return 2;
                if (op == 6'h04) return 8;
                if (op == 6'h02) return 9;
                return 10;
            end
            2: return (op == 6'h2B) ? 5 : 3;
            3: return 4;
            6: return ov ? 11 : 7;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2, 3, 4, 5: return "R7";
            6: return "R4";
            7: return "R5";
            8, 9: return "R8";
            10: return "R3";
            11: return "R6";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [19:0] act_ctrl();
        return {a_sel, b_sel, alu_func, dst_rd_sel, rf_we, wb_from_mem, addr_from_alu,
                mem_rd, mem_wr, instr_we, pc_we, pc_we_if_zero, pc_src, epc_we, cause_we, cause_code};
    endfunction

    // Every check also covers R9 (zero defaults) and R10 (function codes).
    task automatic check_state(input int s, input logic [5:0] op, input logic ov);
        checks++;
        if (act_ctrl() !== exp_ctrl(s)) begin
            errors++;
            $display("FAIL %s (R9 R10) op=%h ovf=%0b state=%0d actual=%h expected=%h",
                     tag_of(s), op, ov, s, act_ctrl(), exp_ctrl(s));
        end
    endtask

    initial begin
        int s;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_state(0, opcode, alu_overflow); // R1 during reset
        rst = 1'b0;
        s = 0;
        // Sweep every opcode with the overflow flag held low and then high.
        for (int op = 0; op < 64; op++) begin
            for (int ov = 0; ov < 2; ov++) begin
                opcode = 6'(op);
                alu_overflow = ov[0];
                for (int cyc = 0; cyc < 8; cyc++) begin
                    check_state(s, opcode, alu_overflow);
                    s = model_next(s, opcode, alu_overflow);
                    @(negedge clk);
                    if (s == 0) break;
                end
                check_state(s, opcode, alu_overflow);
            end
        end
        // R1: reset from inside a load sequence returns to fetch.
        opcode = 6'h23;
        alu_overflow = 1'b0;
        repeat (3) @(negedge clk);
        check_state(3, opcode, alu_overflow);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_state(0, opcode, alu_overflow);
        @(negedge clk);
        check_state(1, opcode, alu_overflow);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R1) actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule